// File: doc/BRIEF.md
# Hypervisor Interrupt Status Register Bank

This block is a small bank of privileged control registers. It keeps the head and tail pointers of four message queues, a hypervisor pending word, a hypervisor state word, a trap base address and a read-only version word. From these registers it drives level interrupt requests toward the trap logic. The queue storage itself is elsewhere. This bank only records where software has read to and where producers have written to. A queue interrupt stays high while unread entries remain, which means its head and tail differ.

Software reaches the bank through a single request port that carries a valid, a write flag, a 5-bit address and a data word. Each request receives a one-cycle response on the next cycle. The response carries read data and an error flag. The current trap level enters as a plain input and takes part only in the trap-level-zero request. Every interrupt line is combinational from the stored registers and that input, so a change in the trap level shows on the line in the same cycle.

Top module: `hv_irq_regbank`

## Requirements
- R1: Queue pointers sit at addresses 0x00 to 0x07. Address bit 0 selects the tail (1) or the head (0), and bits 2:1 select the queue: 0 is cpu mondo, 1 is device mondo, 2 is resumable error, 3 is nonresumable error. Each pointer keeps the low 16 bits of the written data. irq_cpu_q, irq_dev_q and irq_res_err are high exactly when their queue's head differs from its tail.
- R2: The nonresumable error pointers (0x06 and 0x07) can be written and read back, but they drive no interrupt line.
- R3: The pending word at 0x08 keeps the low 16 bits of the written data. irq_hv_pend is high exactly when it is nonzero.
- R4: The state word at 0x09 keeps bits 11:0 of the written data and reads back zero above them. Bit 11 (id) reads back as 1 after every write, whatever the data was.
- R5: irq_tl_zero is high exactly when state bit 0 (tlz) is 1, state bit 2 (hpriv) is 0 and the tl input equals 0. It follows tl in the same cycle.
- R6: The trap base at 0x0A stores the written word with bits 14:0 forced to zero, and it reads back with those bits at zero.
- R7: A read of 0x0B returns the window count (8) in bits 7:0, the maximum trap level (6) in bits 15:8 and the maximum global level (3) from bit 16 upward, which gives 0x30608. A write to 0x0B is refused with an error.
- R8: A request to any address from 0x0C to 0x1F, or a write to 0x0B, sets rsp_err for one cycle, returns zero data and changes no register.
- R9: Every request with req_valid high produces rsp_valid on the following cycle only. Read data appears in that cycle, and a write returns zero data.
- R10: After reset, all pointers, the pending word and the trap base are zero, the state word holds only the id bit (0x800), and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Register address |
| req_wdata | input | 64 | Write data |
| tl | input | 3 | Current trap level |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request was refused |
| rsp_rdata | output | 64 | Read data of the previous request |
| irq_cpu_q | output | 1 | Cpu mondo queue not empty |
| irq_dev_q | output | 1 | Device mondo queue not empty |
| irq_res_err | output | 1 | Resumable error queue not empty |
| irq_hv_pend | output | 1 | Hypervisor pending word nonzero |
| irq_tl_zero | output | 1 | Trap-level-zero request |

## Verification
The trap-level-zero line can be affected in one cycle by two things at once: a state word write and a change of the tl input. The bench lowers tl to zero in the same cycle as a write that clears tlz. The model expects the line high before the edge, because the old tlz meets the new tl, and low after it. A second collision is a refused version or unmapped write in the cycle where a queue is non-empty. There, the model expects the error response while the queue line holds its level.

// File: rtl/hv_regbank_pkg.sv
// Package: address map and queue indices shared by the register bank.
// Assumes a 5-bit register address. The interrupting queues occupy indices
// 0..NUM_IRQ_Q-1 and the silent queue follows them.
package hv_regbank_pkg;
    localparam int REG_ADDR_W = 5;
    localparam int NUM_Q      = 4;
    localparam int NUM_IRQ_Q  = 3;
    localparam int Q_CPU      = 0;
    localparam int Q_DEV      = 1;
    localparam int Q_RES      = 2;
    localparam int Q_NRES     = 3;

    localparam logic [REG_ADDR_W-1:0] A_QUEUE_END = 5'h08;
    localparam logic [REG_ADDR_W-1:0] A_PEND      = 5'h08;
    localparam logic [REG_ADDR_W-1:0] A_HSTATE    = 5'h09;
    localparam logic [REG_ADDR_W-1:0] A_TBASE     = 5'h0A;
    localparam logic [REG_ADDR_W-1:0] A_VERSION   = 5'h0B;
endpackage

// File: rtl/hv_access_decode.sv
// Module: turns one request into per-register write strobes and a refusal
// flag. Assumes the package address map. Purely combinational.
module hv_access_decode
    import hv_regbank_pkg::*;
(
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [REG_ADDR_W-1:0] req_addr,
    output logic [NUM_Q-1:0]      wr_head,
    output logic [NUM_Q-1:0]      wr_tail,
    output logic                  wr_pend,
    output logic                  wr_hstate,
    output logic                  wr_tbase,
    output logic                  refuse
);
    logic do_write;
    assign do_write = req_valid && req_write;

    // Decode address into one write strobe, or a refusal for bad accesses.
    always_comb begin
        wr_head   = '0;
        wr_tail   = '0;
        wr_pend   = 1'b0;
        wr_hstate = 1'b0;
        wr_tbase  = 1'b0;
        refuse    = 1'b0;
        if (req_addr < A_QUEUE_END) begin
            if (do_write) begin
                if (req_addr[0]) wr_tail[req_addr[2:1]] = 1'b1;
                else             wr_head[req_addr[2:1]] = 1'b1;
            end
        end else begin
            case (req_addr)
                A_PEND:    wr_pend   = do_write;
                A_HSTATE:  wr_hstate = do_write;
                A_TBASE:   wr_tbase  = do_write;
                A_VERSION: refuse    = do_write;
                default:   refuse    = req_valid;
            endcase
        end
    end
endmodule

// File: rtl/hv_queue_pair.sv
// Module: head and tail pointer storage for one message queue.
// Assumes strobes from the decoder are one-hot or idle; both may not fire.
module hv_queue_pair #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_head,
    input  logic             wr_tail,
    input  logic [PTR_W-1:0] wdata,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail
);
    // Head pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)       head <= '0;
        else if (wr_head) head <= wdata;
    end

    // Tail pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)       tail <= '0;
        else if (wr_tail) tail <= wdata;
    end
endmodule

// File: rtl/hv_ctrl_regs.sv
// Module: pending word, hypervisor state word and trap base, with the
// pending and trap-level-zero requests. Assumes ID_BIT < HS_W and
// BASE_LOW < DATA_W. Only the unmasked base bits are stored.
module hv_ctrl_regs #(
    parameter int DATA_W    = 64,
    parameter int PEND_W    = 16,
    parameter int HS_W      = 12,
    parameter int ID_BIT    = 11,
    parameter int TLZ_BIT   = 0,
    parameter int HPRIV_BIT = 2,
    parameter int BASE_LOW  = 15,
    parameter int TL_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pend,
    input  logic              wr_hstate,
    input  logic              wr_tbase,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TL_W-1:0]   tl,
    output logic [PEND_W-1:0] pend,
    output logic [HS_W-1:0]   hstate,
    output logic [DATA_W-1:0] tbase,
    output logic              irq_pend,
    output logic              irq_tlz
);
    localparam logic [HS_W-1:0] ID_MASK = HS_W'(1) << ID_BIT;

    logic [DATA_W-1:BASE_LOW] tbase_hi;

    // Pending word register.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= '0;
        else if (wr_pend) pend <= wdata[PEND_W-1:0];
    end

    // State word register; the id bit is set by every write.
    always_ff @(posedge clk) begin
        if (!rst_n)         hstate <= ID_MASK;
        else if (wr_hstate) hstate <= wdata[HS_W-1:0] | ID_MASK;
    end

    // Trap base register; only the bits above the masked field exist.
    always_ff @(posedge clk) begin
        if (!rst_n)        tbase_hi <= '0;
        else if (wr_tbase) tbase_hi <= wdata[DATA_W-1:BASE_LOW];
    end

    // Rebuild the full base word with the low field at zero.
    assign tbase = {tbase_hi, {BASE_LOW{1'b0}}};

    // Level requests derived from stored words and the trap level.
    assign irq_pend = |pend;
    assign irq_tlz  = hstate[TLZ_BIT] && !hstate[HPRIV_BIT] && (tl == '0);
endmodule

// File: rtl/hv_irq_regbank.sv
// Module: top of the hypervisor interrupt status register bank. Decodes
// requests, holds queue pointers and control words, answers one cycle
// later and drives the level interrupt lines combinationally.
// Assumes a single requester and the package address map.
module hv_irq_regbank
    import hv_regbank_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int PTR_W     = 16,
    parameter int PEND_W    = 16,
    parameter int HS_W      = 12,
    parameter int ID_BIT    = 11,
    parameter int TLZ_BIT   = 0,
    parameter int HPRIV_BIT = 2,
    parameter int BASE_LOW  = 15,
    parameter int TL_W      = 3,
    parameter int WIN_COUNT = 8,
    parameter int TL_MAX    = 6,
    parameter int GL_MAX    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [REG_ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [TL_W-1:0]       tl,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  irq_cpu_q,
    output logic                  irq_dev_q,
    output logic                  irq_res_err,
    output logic                  irq_hv_pend,
    output logic                  irq_tl_zero
);
    localparam logic [DATA_W-1:0] VERSION_WORD =
        (DATA_W'(GL_MAX) << 16) |
        (DATA_W'(TL_MAX & 255) << 8) |
        DATA_W'(WIN_COUNT & 255);

    logic [NUM_Q-1:0]     wr_head;
    logic [NUM_Q-1:0]     wr_tail;
    logic                 wr_pend;
    logic                 wr_hstate;
    logic                 wr_tbase;
    logic                 refuse;
    logic [PTR_W-1:0]     q_head [NUM_Q];
    logic [PTR_W-1:0]     q_tail [NUM_Q];
    logic [NUM_IRQ_Q-1:0] q_irq;
    logic [PEND_W-1:0]    pend;
    logic [HS_W-1:0]      hstate;
    logic [DATA_W-1:0]    tbase;
    logic [DATA_W-1:0]    rd_val;

    hv_access_decode u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .wr_head   (wr_head),
        .wr_tail   (wr_tail),
        .wr_pend   (wr_pend),
        .wr_hstate (wr_hstate),
        .wr_tbase  (wr_tbase),
        .refuse    (refuse)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        hv_queue_pair #(.PTR_W(PTR_W)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_head (wr_head[q]),
            .wr_tail (wr_tail[q]),
            .wdata   (req_wdata[PTR_W-1:0]),
            .head    (q_head[q]),
            .tail    (q_tail[q])
        );
    end

    // Only the leading queues raise a request; the silent one is excluded.
    for (genvar q = 0; q < NUM_IRQ_Q; q++) begin : g_qirq
        assign q_irq[q] = (q_head[q] != q_tail[q]);
    end

    hv_ctrl_regs #(
        .DATA_W    (DATA_W),
        .PEND_W    (PEND_W),
        .HS_W      (HS_W),
        .ID_BIT    (ID_BIT),
        .TLZ_BIT   (TLZ_BIT),
        .HPRIV_BIT (HPRIV_BIT),
        .BASE_LOW  (BASE_LOW),
        .TL_W      (TL_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_pend   (wr_pend),
        .wr_hstate (wr_hstate),
        .wr_tbase  (wr_tbase),
        .wdata     (req_wdata),
        .tl        (tl),
        .pend      (pend),
        .hstate    (hstate),
        .tbase     (tbase),
        .irq_pend  (irq_hv_pend),
        .irq_tlz   (irq_tl_zero)
    );

    // Read multiplexer over all mapped registers.
    always_comb begin
        rd_val = '0;
        if (req_addr < A_QUEUE_END) begin
            rd_val[PTR_W-1:0] = req_addr[0] ? q_tail[req_addr[2:1]]
                                            : q_head[req_addr[2:1]];
        end else begin
            case (req_addr)
                A_PEND:    rd_val[PEND_W-1:0] = pend;
                A_HSTATE:  rd_val[HS_W-1:0]   = hstate;
                A_TBASE:   rd_val             = tbase;
                A_VERSION: rd_val             = VERSION_WORD;
                default:   rd_val             = '0;
            endcase
        end
    end

    // Response register: one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= refuse;
            rsp_rdata <= (req_valid && !req_write && !refuse) ? rd_val : '0;
        end
    end

    assign irq_cpu_q   = q_irq[Q_CPU];
    assign irq_dev_q   = q_irq[Q_DEV];
    assign irq_res_err = q_irq[Q_RES];
endmodule

// File: rtl/hv_regbank_checker.sv
// Module: temporal checks on the register bank ports, bound to the top.
module hv_regbank_checker #(
    parameter int DATA_W    = 64,
    parameter int TL_W      = 3,
    parameter int ID_BIT    = 11,
    parameter int BASE_LOW  = 15,
    parameter int WIN_COUNT = 8,
    parameter int TL_MAX    = 6,
    parameter int GL_MAX    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [4:0]        req_addr,
    input logic [TL_W-1:0]   tl,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              irq_cpu_q,
    input logic              irq_dev_q,
    input logic              irq_res_err,
    input logic              irq_hv_pend,
    input logic              irq_tl_zero
);
    localparam logic [DATA_W-1:0] VER =
        (DATA_W'(GL_MAX) << 16) | (DATA_W'(TL_MAX & 255) << 8) |
        DATA_W'(WIN_COUNT & 255);

    logic rd_req;
    assign rd_req = req_valid && !req_write;

    AST_QIRQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(req_valid && req_write)) |-> $stable({irq_cpu_q, irq_dev_q, irq_res_err})); // R1
    AST_NRES_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_write && req_addr[4:1] == 4'd3) |->
        $stable({irq_cpu_q, irq_dev_q, irq_res_err, irq_hv_pend})); // R2
    AST_ID_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(rd_req && req_addr == 5'h09)) |-> rsp_rdata[ID_BIT]); // R4
    AST_TLZ_AT_LEVEL0: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tl_zero |-> (tl == '0)); // R5
    AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(rd_req && req_addr == 5'h0A)) |-> (rsp_rdata[BASE_LOW-1:0] == '0)); // R6
    AST_VERSION_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(rd_req && req_addr == 5'h0B)) |-> (rsp_rdata == VER)); // R7
    AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $stable({irq_cpu_q, irq_dev_q, irq_res_err, irq_hv_pend})); // R8
    AST_ERR_HAS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R8
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid)); // R9
endmodule

bind hv_irq_regbank hv_regbank_checker #(
    .DATA_W(DATA_W), .TL_W(TL_W), .ID_BIT(ID_BIT), .BASE_LOW(BASE_LOW),
    .WIN_COUNT(WIN_COUNT), .TL_MAX(TL_MAX), .GL_MAX(GL_MAX)
) u_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .tl(tl), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .irq_cpu_q(irq_cpu_q), .irq_dev_q(irq_dev_q),
    .irq_res_err(irq_res_err), .irq_hv_pend(irq_hv_pend),
    .irq_tl_zero(irq_tl_zero)
);

// File: tb/hv_irq_regbank_bench.sv
// Bench: behavioural model of the bank compared on every clock.
module hv_irq_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [2:0]  tl = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic        irq_cpu_q, irq_dev_q, irq_res_err, irq_hv_pend, irq_tl_zero;

    int n_chk = 0;
    int n_err = 0;

    logic [15:0] m_head [4];
    logic [15:0] m_tail [4];
    logic [15:0] m_pend;
    logic [11:0] m_hs;
    logic [63:0] m_base;

    localparam logic [63:0] VER = 64'h30608;

    always #10 clk = ~clk;

    hv_irq_regbank u_hv_irq_regbank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .tl(tl),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .irq_cpu_q(irq_cpu_q), .irq_dev_q(irq_dev_q), .irq_res_err(irq_res_err),
        .irq_hv_pend(irq_hv_pend), .irq_tl_zero(irq_tl_zero)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input logic [2:0] t);
        chk("R1 cpu queue line", 64'(irq_cpu_q), 64'(m_head[0] != m_tail[0]));
        chk("R1 dev queue line", 64'(irq_dev_q), 64'(m_head[1] != m_tail[1]));
        chk("R1 res queue line", 64'(irq_res_err), 64'(m_head[2] != m_tail[2]));
        chk("R3 pending line", 64'(irq_hv_pend), 64'(m_pend != 0));
        chk("R5 tl-zero line", 64'(irq_tl_zero), 64'(m_hs[0] && !m_hs[2] && t == 0));
    endtask

    // One request cycle: drive, check lines before the edge, model, check response.
    task automatic step(input bit v, input bit w, input logic [4:0] a,
                        input logic [63:0] d, input logic [2:0] t);
        logic [63:0] e_rd;
        bit e_err;
        int q;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; tl = t;
        #1;
        chk_irq(t);
        e_rd = '0; e_err = 1'b0;
        if (v) begin
            if (a < 5'h08) begin
                q = int'(a[2:1]);
                if (w) begin
                    if (a[0]) m_tail[q] = d[15:0]; else m_head[q] = d[15:0];
                end else e_rd = 64'(a[0] ? m_tail[q] : m_head[q]);
            end else if (a == 5'h08) begin
                if (w) m_pend = d[15:0]; else e_rd = 64'(m_pend);
            end else if (a == 5'h09) begin
                if (w) m_hs = d[11:0] | 12'h800; else e_rd = 64'(m_hs);
            end else if (a == 5'h0A) begin
                if (w) m_base = d & ~64'h7FFF; else e_rd = m_base;
            end else if (a == 5'h0B) begin
                if (w) e_err = 1'b1; else e_rd = VER;
            end else e_err = 1'b1;
        end
        @(posedge clk);
        #1;
        chk("R9 response valid", 64'(rsp_valid), 64'(v));
        chk("R8 response error", 64'(rsp_err), 64'(e_err));
        chk("R9 response data", rsp_rdata, e_rd);
    endtask

    task automatic wr(input logic [4:0] a, input logic [63:0] d, input logic [2:0] t);
        step(1'b1, 1'b1, a, d, t);
    endtask

    task automatic rd(input logic [4:0] a, input logic [2:0] t);
        step(1'b1, 1'b0, a, '0, t);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_head[i] = '0; m_tail[i] = '0; end
        m_pend = '0; m_hs = 12'h800; m_base = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state at the ports
        chk("R10 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk("R10 lines after reset", 64'({irq_cpu_q, irq_dev_q, irq_res_err, irq_hv_pend, irq_tl_zero}), 64'd0);
        for (int a = 0; a < 12; a++) rd(5'(a), 3'd0);          // R10 reset contents
        // R1: each interrupting queue rises on tail write, falls on head catch-up
        wr(5'h01, 64'h5, 3'd1);
        wr(5'h03, 64'hABCD_1234, 3'd1);
        wr(5'h05, 64'hFFFF, 3'd1);
        rd(5'h03, 3'd1);
        wr(5'h00, 64'h5, 3'd1);
        wr(5'h02, 64'h1234, 3'd1);
        wr(5'h04, 64'h1_FFFF, 3'd1);                             // R1 upper bits dropped
        wr(5'h04, 64'h7, 3'd2);
        // R2: silent queue pointers stored, no line moves
        wr(5'h07, 64'h33, 3'd2);
        rd(5'h07, 3'd2);
        wr(5'h06, 64'h44, 3'd2);
        rd(5'h06, 3'd2);
        // R3: pending word
        wr(5'h08, 64'hFFFF_0000_0000_0040, 3'd2);
        rd(5'h08, 3'd2);
        wr(5'h08, 64'hFFFF_0000, 3'd2);                          // R3 low half zero
        wr(5'h08, 64'h8000, 3'd2);
        wr(5'h08, 64'h0, 3'd2);
        // R4 and R5: state word and trap-level-zero
        wr(5'h09, 64'h0, 3'd0);
        rd(5'h09, 3'd0);
        wr(5'h09, 64'hFFFF_F001, 3'd3);                          // R4 upper dropped, tlz set
        step(1'b0, 1'b0, 5'h00, '0, 3'd0);                        // R5 tl reaches zero
        step(1'b0, 1'b0, 5'h00, '0, 3'd7);
        wr(5'h09, 64'h5, 3'd0);                                  // R5 hpriv blocks
        rd(5'h09, 3'd0);
        wr(5'h09, 64'h1, 3'd0);                                  // R5 rises after edge
        wr(5'h09, 64'h0, 3'd0);                                  // R5 write collides with tl=0
        wr(5'h09, 64'h1, 3'd4);
        wr(5'h09, 64'h0, 3'd0);                                  // R5 clear while tl falls
        step(1'b0, 1'b0, 5'h00, '0, 3'd0);
        // R6: trap base masking
        wr(5'h0A, 64'hFFFF_FFFF_FFFF_FFFF, 3'd1);
        rd(5'h0A, 3'd1);
        wr(5'h0A, 64'h0000_0000_0000_8000, 3'd1);
        rd(5'h0A, 3'd1);
        wr(5'h0A, 64'h0000_0000_0000_7FFF, 3'd1);
        rd(5'h0A, 3'd1);
        // R7 and R8: version read, refused writes, unmapped accesses with a queue busy
        wr(5'h01, 64'h9, 3'd1);
        wr(5'h08, 64'h2, 3'd1);
        rd(5'h0B, 3'd1);
        wr(5'h0B, 64'hFFFF_FFFF_FFFF_FFFF, 3'd1);
        rd(5'h0B, 3'd1);
        for (int a = 12; a < 32; a++) begin
            wr(5'(a), 64'hFFFF_FFFF_FFFF_FFFF, 3'd0);
            rd(5'(a), 3'd0);
        end
        for (int a = 0; a < 12; a++) rd(5'(a), 3'd0);           // R8 nothing changed
        // R9: idle cycles and back-to-back requests
        step(1'b0, 1'b1, 5'h01, 64'h77, 3'd2);                  // R9 write without valid ignored
        rd(5'h01, 3'd2);
        wr(5'h00, 64'h9, 3'd2);
        rd(5'h00, 3'd2);
        step(1'b0, 1'b0, 5'h00, '0, 3'd2);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule